// File: doc/BRIEF.md
# DMA Channel Transfer Counter

This block holds the control state and the item counter of a single DMA channel. Software programs a channel enable, a circular-mode bit and three interrupt enables through a small register port, and loads an 18-bit count of data items. A datapath engine reports each finished item (one read followed by one write) with a one-cycle `xfer_done` pulse and a failed access with an `xfer_err` pulse. The block counts down, decides whether the channel may request service, and raises half-transfer, transfer-complete and transfer-error flags. The flags are cleared by writing ones to a clear register, and a single interrupt line combines them.

In circular mode the count reloads the value software last loaded once it runs out, so a ring buffer can be served without software help. A transfer error disables the channel and keeps it disabled until software has cleared the error flag. A zero count stops all service, even with the channel enabled.

Top module: `dma_chan_counter`

## Requirements
- R1: After reset, every register reads zero, `chan_req` is 0 and `irq` is 0. Register map: address 0 control, 1 count, 2 flag status (read), 3 flag clear (write ones).
- R2: Each `xfer_done` pulse while enabled with a non-zero count lowers the count by one. The count occupies bits 17:0; a read of address 1 returns zero in bits 31:18 and a write keeps only bits 17:0.
- R3: With circular mode off, the count reaches zero, stays there under further `xfer_done` pulses, sets the transfer-complete flag and drops `chan_req`.
- R4: With circular mode on, the item that would bring the count to zero reloads it with the last loaded value instead and sets the transfer-complete flag.
- R5: `chan_req` is 1 only while the channel is enabled and the count is non-zero; with a zero count, `xfer_done` pulses change nothing.
- R6: Writes to the count while the channel is enabled are ignored, for both the visible count and the reload value.
- R7: An `xfer_err` pulse while enabled clears the enable bit and sets the error flag. While the error flag is set, writing 1 to the enable bit leaves it 0 (other control bits are written). After the error flag is cleared, the enable bit can be set again.
- R8: The half-transfer flag sets on the item that leaves the count equal to the loaded value shifted right by one.
- R9: Control bits: 0 enable, 1 complete-interrupt enable, 2 half-interrupt enable, 3 error-interrupt enable, 4 circular. `irq` is the OR of each flag ANDed with its enable.
- R10: Status bits: 0 global, 1 complete, 2 half, 3 error. Any flag event also sets the global flag. Writing 1 to clear bit 1, 2 or 3 clears that flag only; writing 1 to clear bit 0 clears all four. Flags do not clear otherwise.
- R11: `xfer_done` pulses while the channel is disabled leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after `reg_re` |
| reg_rvalid | output | 1 | Read data valid |
| xfer_done | input | 1 | One item finished |
| xfer_err | input | 1 | Access error from the datapath |
| chan_req | output | 1 | Channel may request service |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default widths: an 18-bit count on a 32-bit register port. With this width, a write of a value with high bits set shows the count truncating at bit 18 and the reserved bits reading back as zero. Small programmed counts (8 and 4) make the half point, the run to zero and the circular reload reachable within a few dozen cycles, and the error lockout is exercised on a running circular channel.

// File: rtl/dmacnt_pkg.sv
package dmacnt_pkg;
  localparam int ADDR_W = 2;
  localparam int CTRL_W = 5;
  localparam int FLAG_N = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_CNT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
  localparam logic [ADDR_W-1:0] A_CLR  = 2'd3;

  // flag bit positions
  localparam int F_GL = 0;
  localparam int F_TC = 1;
  localparam int F_HT = 2;
  localparam int F_TE = 3;

  typedef struct packed {
    logic circ;
    logic teie;
    logic htie;
    logic tcie;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/dmacnt_regs.sv
module dmacnt_regs
  import dmacnt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              err_evt,
  input  logic              te_flag,
  output ctrl_t             ctrl
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (ctrl_we) begin
        ctrl_q <= ctrl_t'(ctrl_wdata);
        // enable stays low while an error is pending
        if (te_flag) ctrl_q.en <= 1'b0;
      end
      if (err_evt) ctrl_q.en <= 1'b0;
    end
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/dmacnt_count.sv
module dmacnt_count #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_we,
  input  logic [CNT_W-1:0] sw_data,
  input  logic             en,
  input  logic             circ,
  input  logic             done,
  input  logic             err,
  output logic [CNT_W-1:0] cnt,
  output logic             nz,
  output logic             tc_evt,
  output logic             ht_evt
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] shadow_q;
  logic [CNT_W-1:0] cnt_dec;
  logic [CNT_W-1:0] half_mark;
  logic             serve;
  logic             last_item;

  assign nz        = |cnt_q;
  assign cnt_dec   = cnt_q - 1'b1;
  assign half_mark = shadow_q >> 1;
  assign serve     = en && nz && done && !err;
  assign last_item = (cnt_dec == '0);

  always_comb begin
    tc_evt = serve && last_item;
    ht_evt = serve && (cnt_dec == half_mark);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      shadow_q <= '0;
    end else if (sw_we && !en) begin
      cnt_q    <= sw_data;
      shadow_q <= sw_data;
    end else if (serve) begin
      cnt_q <= (last_item && circ) ? shadow_q : cnt_dec;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/dmacnt_flags.sv
module dmacnt_flags
  import dmacnt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tc_set,
  input  logic              ht_set,
  input  logic              te_set,
  input  logic              clr_we,
  input  logic [FLAG_N-1:0] clr_bits,
  input  ctrl_t             ctrl,
  output logic [FLAG_N-1:0] flags,
  output logic              irq
);
  logic [FLAG_N-1:0] set_vec;
  logic [FLAG_N-1:0] ie_vec;
  logic [FLAG_N-1:0] flag_q;
  logic              clr_all;

  assign clr_all = clr_we && clr_bits[F_GL];

  always_comb begin
    set_vec       = '0;
    set_vec[F_TC] = tc_set;
    set_vec[F_HT] = ht_set;
    set_vec[F_TE] = te_set;
    set_vec[F_GL] = tc_set | ht_set | te_set;
    ie_vec        = '0;
    ie_vec[F_TC]  = ctrl.tcie;
    ie_vec[F_HT]  = ctrl.htie;
    ie_vec[F_TE]  = ctrl.teie;
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[i] <= 1'b0;
      end else if (set_vec[i]) begin
        flag_q[i] <= 1'b1;
      end else if (clr_all || (clr_we && clr_bits[i])) begin
        flag_q[i] <= 1'b0;
      end
    end
  end

  assign flags = flag_q;
  assign irq   = |(flag_q & ie_vec);
endmodule

// File: rtl/dma_chan_counter.sv
module dma_chan_counter
  import dmacnt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  input  logic              xfer_done,
  input  logic              xfer_err,
  output logic              chan_req,
  output logic              irq
);
  localparam int PAD_CNT  = DATA_W - CNT_W;
  localparam int PAD_CTRL = DATA_W - CTRL_W;
  localparam int PAD_FLAG = DATA_W - FLAG_N;

  ctrl_t             ctrl_w;
  logic [CNT_W-1:0]  cnt_w;
  logic              nz_w;
  logic              tc_evt;
  logic              ht_evt;
  logic              err_evt;
  logic [FLAG_N-1:0] flags_w;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic              unused_wdata_hi;

  assign err_evt         = xfer_err && ctrl_w.en;
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CNT_W];

  dmacnt_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (reg_we && reg_addr == A_CTRL),
    .ctrl_wdata (reg_wdata[CTRL_W-1:0]),
    .err_evt    (err_evt),
    .te_flag    (flags_w[F_TE]),
    .ctrl       (ctrl_w)
  );

  dmacnt_count #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .sw_we   (reg_we && reg_addr == A_CNT),
    .sw_data (reg_wdata[CNT_W-1:0]),
    .en      (ctrl_w.en),
    .circ    (ctrl_w.circ),
    .done    (xfer_done),
    .err     (err_evt),
    .cnt     (cnt_w),
    .nz      (nz_w),
    .tc_evt  (tc_evt),
    .ht_evt  (ht_evt)
  );

  dmacnt_flags u_flags (
    .clk      (clk),
    .rst      (rst),
    .tc_set   (tc_evt),
    .ht_set   (ht_evt),
    .te_set   (err_evt),
    .clr_we   (reg_we && reg_addr == A_CLR),
    .clr_bits (reg_wdata[FLAG_N-1:0]),
    .ctrl     (ctrl_w),
    .flags    (flags_w),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= reg_re;
      if (reg_re) begin
        case (reg_addr)
          A_CTRL:  rdata_q <= {{PAD_CTRL{1'b0}}, ctrl_w};
          A_CNT:   rdata_q <= {{PAD_CNT{1'b0}}, cnt_w};
          A_STAT:  rdata_q <= {{PAD_FLAG{1'b0}}, flags_w};
          default: rdata_q <= '0;
        endcase
      end
    end
  end

  assign reg_rdata  = rdata_q;
  assign reg_rvalid = rvalid_q;
  assign chan_req   = ctrl_w.en && nz_w;
endmodule

// File: rtl/dmacnt_checker.sv
module dmacnt_checker
  import dmacnt_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              xfer_done,
  input logic              xfer_err,
  input logic              en,
  input logic [CNT_W-1:0]  cnt,
  input logic [FLAG_N-1:0] flags,
  input logic              irq
);
  p_dec_one_r2: assert property (@(posedge clk) disable iff (rst)
    (en && cnt > 1 && xfer_done && !xfer_err) |=> cnt == $past(cnt) - 1'b1);

  p_zero_stays_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !(reg_we && reg_addr == A_CNT)) |=> cnt == '0);

  p_cnt_locked_r6: assert property (@(posedge clk) disable iff (rst)
    (en && !xfer_done) |=> $stable(cnt));

  p_err_clears_en_r7: assert property (@(posedge clk) disable iff (rst)
    (en && xfer_err) |=> !en);

  p_en_locked_r7: assert property (@(posedge clk) disable iff (rst)
    flags[F_TE] |-> !en);

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> flags != '0);
endmodule

bind dma_chan_counter dmacnt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .xfer_done (xfer_done),
  .xfer_err  (xfer_err),
  .en        (ctrl_w.en),
  .cnt       (cnt_w),
  .flags     (flags_w),
  .irq       (irq)
);

// File: tb/dma_chan_counter_test.sv
module dma_chan_counter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        xfer_done = 1'b0;
  logic        xfer_err = 1'b0;
  logic        chan_req;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_counter uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .xfer_done(xfer_done), .xfer_err(xfer_err),
    .chan_req(chan_req), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (!rst && reg_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard actual=%h expected=none", reg_rdata);
      end else begin
        chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic items(int n);
    for (int i = 0; i < n; i++) begin
      xfer_done = 1'b1;
      @(negedge clk);
    end
    xfer_done = 1'b0;
  endtask

  task automatic err_pulse();
    xfer_err = 1'b1;
    @(negedge clk);
    xfer_err = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 chan_req", {31'b0, chan_req}, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(2'd0, 32'h0, "R1 ctrl");
    rd(2'd1, 32'h0, "R1 count");
    rd(2'd2, 32'h0, "R1 status");

    // R5 zero count blocks service even when enabled
    wr(2'd0, 32'h1);
    chk("R5 chan_req zero count", {31'b0, chan_req}, 32'h0);
    items(2);
    rd(2'd1, 32'h0, "R5 count stays zero");
    rd(2'd2, 32'h0, "R5 no flags");
    wr(2'd0, 32'h0);

    // R2 width truncation, reserved bits zero; R11 disabled ignores items
    wr(2'd1, 32'hFFFF_0008);
    rd(2'd1, 32'h0003_0008, "R2 reserved bits");
    items(3);
    rd(2'd1, 32'h0003_0008, "R11 disabled count");
    wr(2'd1, 32'd8);

    // normal run: enable with both interrupt enables
    wr(2'd0, 32'h7);
    chk("R5 chan_req active", {31'b0, chan_req}, 32'h1);
    wr(2'd1, 32'd5);
    rd(2'd1, 32'd8, "R6 write ignored");
    items(3);
    rd(2'd1, 32'd5, "R2 decrement");
    rd(2'd2, 32'h0, "R8 not yet half");
    chk("R9 irq idle", {31'b0, irq}, 32'h0);
    items(1);
    rd(2'd2, 32'h5, "R8 half flag");
    chk("R9 irq half", {31'b0, irq}, 32'h1);
    wr(2'd3, 32'h4);
    rd(2'd2, 32'h1, "R10 clear half only");
    chk("R10 irq after clear", {31'b0, irq}, 32'h0);
    items(4);
    rd(2'd1, 32'h0, "R3 reached zero");
    rd(2'd2, 32'h3, "R3 complete flag");
    chk("R3 chan_req dropped", {31'b0, chan_req}, 32'h0);
    chk("R9 irq complete", {31'b0, irq}, 32'h1);
    items(2);
    rd(2'd1, 32'h0, "R3 stays zero");
    wr(2'd3, 32'h1);
    rd(2'd2, 32'h0, "R10 clear all");

    // circular mode, no interrupt enables
    wr(2'd0, 32'h0);
    wr(2'd1, 32'd4);
    wr(2'd0, 32'h11);
    wr(2'd1, 32'd9);
    items(2);
    rd(2'd2, 32'h5, "R8 circular half");
    chk("R9 half gated off", {31'b0, irq}, 32'h0);
    items(2);
    rd(2'd1, 32'd4, "R4 reload");
    rd(2'd2, 32'h7, "R4 complete flag");
    chk("R4 chan_req after reload", {31'b0, chan_req}, 32'h1);
    wr(2'd3, 32'h1);

    // R7 error lockout
    err_pulse();
    rd(2'd0, 32'h10, "R7 enable cleared");
    rd(2'd2, 32'h9, "R7 error flag");
    chk("R7 chan_req off", {31'b0, chan_req}, 32'h0);
    wr(2'd0, 32'h19);
    rd(2'd0, 32'h18, "R7 enable locked");
    chk("R9 irq error", {31'b0, irq}, 32'h1);
    wr(2'd3, 32'h8);
    rd(2'd2, 32'h1, "R10 clear error only");
    chk("R9 irq error cleared", {31'b0, irq}, 32'h0);
    wr(2'd0, 32'h19);
    rd(2'd0, 32'h19, "R7 enable after clear");
    rd(2'd1, 32'd4, "R7 count kept");
    chk("R7 chan_req back", {31'b0, chan_req}, 32'h1);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard actual=%0d pending expected=0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule